// File: doc/BRIEF.md
# Upset-Tolerant Two-Wire Output Slave

This block is a slave node on a shared two-wire serial bus whose every byte travels as a 12-bit codeword: eight data bits plus four Hamming check bits, followed by one acknowledge slot. Up to four such nodes share one bus. Each node answers only to its own 7-bit address, whose low bits come from static chip-ID pins. A write frame loads an 8-bit output register. The outputs switch detector sections, and one bit can act as a self-clearing reset pulse. A read frame returns a status byte that carries the chip ID and an upset flag, followed by the present output state.

Every state register, including the protocol engine's own state, is held in three copies. A bitwise majority vote produces the value that the logic uses, and the voted value is written back into all three copies on every clock. A single flipped copy is therefore outvoted at once and repaired on the next edge. Any disagreement among copies sets a sticky flag that the bus can read.

The bus master drives the clock line. The bus data line is wired-AND: the node pulls it low to signal an acknowledge or to send a 0.

Top module: `tmr_bus_slave`

## Requirements
- R1: The node acknowledges a frame only when the decoded first byte holds {BASE_ADDR, chip_id} in bits 7..1. Bit 0 selects the direction: 0 for a write, 1 for a read.
- R2: A codeword sits in bit positions 1..12. The data bits d0..d7 occupy positions 3,5,6,7,9,10,11,12, and the check bits occupy positions 1,2,4,8. Position 12 is sent first. A received codeword whose syndrome lies in 1..12 is corrected at that position and then accepted.
- R3: A received codeword whose syndrome is 13, 14 or 15 is uncorrectable. A data byte of this kind is answered with a released (nack) slot and leaves the outputs unchanged. An address byte of this kind gets no acknowledge.
- R4: An acknowledged data byte in a write frame loads `dout`. All other bus activity leaves `dout` unchanged, apart from the pulse bit of R6.
- R5: A read frame returns two encoded bytes. The first is the status byte: bit 7 is the upset flag, the bits below bit 7 are zero down to the chip ID, and the chip ID sits in the low bits. The second is the current `dout` value.
- R6: With PULSE_EN set, output bit PULSE_BIT goes high on a write that sets it. It stays high for exactly PULSE_LEN clock cycles and then clears by itself.
- R7: Corrupting one of the three copies of a register does not change any output.
- R8: Any copy disagreement sets the status upset flag on the next clock. An accepted write clears the flag.
- R9: After reset, `dout` is 0 and `bus_sda_pull` is 0.
- R10: Frames addressed to another node, including their data bytes, get no acknowledge and have no effect on `dout`.
- R11: `bus_sda_pull` rises only in the cycle after the node has seen a falling edge of the bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the bus lines are oversampled by it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chip_id | input | ID_W | Static chip-ID pins, the low bits of the node address |
| bus_scl | input | 1 | Bus clock line level |
| bus_sda | input | 1 | Resolved bus data line level |
| bus_sda_pull | output | 1 | 1 pulls the bus data line low |
| dout | output | 8 | Voted digital output register |

## Verification
A wrong copy inside a triplicated register shows up only through the upset flag, because the voted outputs stay correct. The bench therefore corrupts a copy directly, checks that `dout` holds its value, and reads the status byte to see the flag. A fault in the protocol state shows at the acknowledge slot of the same byte, or in the first read-back bit. A miscorrected codeword shows as a wrong `dout` one cycle after the twelfth data bit. A pulse counter that is off by one shows as a pulse one cycle too long or too short, which the bench measures exactly.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_ACK   = 3'd2,
    PH_WDATA = 3'd3,
    PH_TX    = 3'd4,
    PH_RACK  = 3'd5,
    PH_SKIP  = 3'd6
  } phase_t;

  typedef struct packed {
    phase_t      ph;
    logic [3:0]  cnt;
    logic [11:0] sh;
    logic        hi;
    logic        ack_go;
    logic        rw;
    logic        data_stage;
    logic        idx;
    logic        pull;
  } link_st_t;

  // XOR of the 1-based positions of all set bits
  function automatic logic [3:0] hc_syndrome(input logic [11:0] c);
    logic [3:0] s;
    s = '0;
    for (int i = 1; i <= 12; i++) begin
      if (c[i-1]) s = s ^ 4'(i);
    end
    return s;
  endfunction

  function automatic logic [11:0] hc_encode(input logic [7:0] d);
    logic [11:0] c;
    logic [3:0]  s;
    c = '0;
    c[2]  = d[0]; c[4]  = d[1]; c[5]  = d[2]; c[6]  = d[3];
    c[8]  = d[4]; c[9]  = d[5]; c[10] = d[6]; c[11] = d[7];
    s = hc_syndrome(c);
    c[0] = s[0]; c[1] = s[1]; c[3] = s[2]; c[7] = s[3];
    return c;
  endfunction

  // returns {ok, data}
  function automatic logic [8:0] hc_decode(input logic [11:0] c);
    logic [3:0]  s;
    logic [11:0] f;
    f = c;
    s = hc_syndrome(c);
    if (s > 4'd12) return 9'h000;
    if (s != 4'd0) f[s - 4'd1] = ~f[s - 4'd1];
    return {1'b1, f[11], f[10], f[9], f[8], f[6], f[5], f[4], f[2]};
  endfunction

endpackage

// File: rtl/tbs_tmr_reg.sv
module tbs_tmr_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         disagree
);

  logic [W-1:0] copy_a;
  logic [W-1:0] copy_b;
  logic [W-1:0] copy_c;

  // all three copies take the new value every cycle (scrubbing)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      copy_a <= '0;
      copy_b <= '0;
      copy_c <= '0;
    end else begin
      copy_a <= d;
      copy_b <= d;
      copy_c <= d;
    end
  end

  assign q        = (copy_a & copy_b) | (copy_b & copy_c) | (copy_a & copy_c);
  assign disagree = |((copy_a ^ copy_b) | (copy_b ^ copy_c));

endmodule

// File: rtl/tbs_link.sv
module tbs_link
  import tbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [6:0] my_addr,
  input  logic [7:0] stat_byte,
  input  logic [7:0] out_byte,
  output logic       wr_stb,
  output logic [7:0] wr_data,
  output logic       pull,
  output logic       scl_fall,
  output logic       disagree
);

  localparam int LW = $bits(link_st_t);

  logic scl_m, scl_s, scl_p;
  logic sda_m, sda_s, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_p <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_p <= sda_s;
    end
  end

  logic scl_rise, start_det, stop_det;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  logic [LW-1:0] cur_v, nx_v;
  link_st_t      cur, nx;
  logic [11:0]   rx_word, tx_word;
  logic [8:0]    dec;

  assign cur  = link_st_t'(cur_v);
  assign nx_v = nx;

  always_comb begin
    nx      = cur;
    wr_stb  = 1'b0;
    rx_word = {cur.sh[10:0], sda_s};
    dec     = hc_decode(rx_word);
    wr_data = dec[7:0];
    tx_word = hc_encode(cur.idx ? out_byte : stat_byte);
    if (start_det) begin
      nx    = '0;
      nx.ph = PH_ADDR;
    end else if (stop_det) begin
      nx = '0;
    end else begin
      case (cur.ph)
        PH_ADDR, PH_WDATA: begin
          if (scl_rise) begin
            nx.sh  = rx_word;
            nx.cnt = cur.cnt + 4'd1;
            if (cur.cnt == 4'd11) begin
              nx.cnt = '0;
              nx.hi  = 1'b0;
              if (cur.ph == PH_ADDR) begin
                if (dec[8] && (dec[7:1] == my_addr)) begin
                  nx.ph         = PH_ACK;
                  nx.ack_go     = 1'b1;
                  nx.rw         = dec[0];
                  nx.data_stage = 1'b0;
                end else begin
                  nx.ph = PH_SKIP;
                end
              end else begin
                nx.ph         = PH_ACK;
                nx.ack_go     = dec[8];
                nx.data_stage = 1'b1;
                wr_stb        = dec[8];
              end
            end
          end
        end
        PH_ACK: begin
          if (scl_rise) begin
            nx.hi = 1'b1;
          end else if (scl_fall && !cur.hi) begin
            nx.pull = cur.ack_go;
          end else if (scl_fall) begin
            nx.pull = 1'b0;
            nx.hi   = 1'b0;
            nx.cnt  = '0;
            if (!cur.ack_go || cur.data_stage) begin
              nx.ph = PH_SKIP;
            end else if (!cur.rw) begin
              nx.ph = PH_WDATA;
            end else begin
              nx.ph   = PH_TX;
              nx.idx  = 1'b0;
              nx.sh   = hc_encode(stat_byte);
              nx.pull = ~nx.sh[11];
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (cur.cnt == 4'd11) begin
              nx.pull = 1'b0;
              nx.ph   = PH_RACK;
              nx.hi   = 1'b0;
            end else begin
              nx.cnt  = cur.cnt + 4'd1;
              nx.sh   = {cur.sh[10:0], 1'b0};
              nx.pull = ~cur.sh[10];
            end
          end
        end
        PH_RACK: begin
          if (scl_rise) begin
            nx.hi = 1'b1;
          end else if (scl_fall && cur.hi) begin
            if (!cur.idx) begin
              nx.idx  = 1'b1;
              nx.ph   = PH_TX;
              nx.cnt  = '0;
              nx.hi   = 1'b0;
              nx.sh   = hc_encode(out_byte);
              nx.pull = ~nx.sh[11];
            end else begin
              nx.ph = PH_SKIP;
            end
          end
        end
        default: nx = cur;
      endcase
    end
  end

  tbs_tmr_reg #(.W(LW)) u_link_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .d        (nx_v),
    .q        (cur_v),
    .disagree (disagree)
  );

  assign pull = cur.pull;

  logic unused_tx;
  assign unused_tx = ^tx_word;

endmodule

// File: rtl/tmr_bus_slave.sv
module tmr_bus_slave #(
  parameter int         ID_W      = 2,
  parameter logic [6:0] BASE_ADDR = 7'b1010000,
  parameter bit         PULSE_EN  = 1'b1,
  parameter int         PULSE_BIT = 7,
  parameter int         PULSE_LEN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] chip_id,
  input  logic            bus_scl,
  input  logic            bus_sda,
  output logic            bus_sda_pull,
  output logic [7:0]      dout
);

  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam int ST_W  = 8 + CNT_W + 1;

  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [6:0] my_addr;
  assign my_addr = {BASE_ADDR[6:ID_W], chip_id};

  logic [ST_W-1:0]  st_q, st_d;
  logic [7:0]       bits, nbits;
  logic [CNT_W-1:0] cnt, ncnt;
  logic             flag_q, nflag;
  logic             st_dis, link_dis, any_dis;
  logic             wr_stb, scl_fall;
  logic [7:0]       wr_data, stat_byte;

  assign bits     = st_q[7:0];
  assign cnt      = st_q[8 +: CNT_W];
  assign flag_q   = st_q[ST_W-1];
  assign any_dis  = st_dis | link_dis;
  assign stat_byte = {flag_q, {(7-ID_W){1'b0}}, chip_id};

  always_comb begin
    nbits = bits;
    ncnt  = cnt;
    nflag = flag_q;
    if (wr_stb) begin
      nbits = wr_data;
      nflag = 1'b0;
      ncnt  = (PULSE_EN && wr_data[PULSE_BIT]) ? CNT_W'(PULSE_LEN - 1) : '0;
    end else if (PULSE_EN && bits[PULSE_BIT]) begin
      if (cnt == '0) nbits[PULSE_BIT] = 1'b0;
      else           ncnt = cnt - 1'b1;
    end
    nflag = nflag | any_dis;
    st_d  = {nflag, ncnt, nbits};
  end

  tbs_tmr_reg #(.W(ST_W)) u_state_tmr (
    .clk      (clk),
    .rst_n    (rst_s),
    .d        (st_d),
    .q        (st_q),
    .disagree (st_dis)
  );

  tbs_link u_link (
    .clk       (clk),
    .rst_n     (rst_s),
    .scl_i     (bus_scl),
    .sda_i     (bus_sda),
    .my_addr   (my_addr),
    .stat_byte (stat_byte),
    .out_byte  (bits),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .pull      (bus_sda_pull),
    .scl_fall  (scl_fall),
    .disagree  (link_dis)
  );

  assign dout = bits;

endmodule

// File: rtl/tmr_bus_slave_chk.sv
module tmr_bus_slave_chk #(
  parameter bit PULSE_EN  = 1'b1,
  parameter int PULSE_BIT = 7
) (
  input logic       clk,
  input logic       rst_s,
  input logic [7:0] dout,
  input logic       wr_stb,
  input logic       pull,
  input logic       scl_fall,
  input logic       dis,
  input logic       flag
);

  localparam logic [7:0] KEEP = PULSE_EN ? ~(8'h01 << PULSE_BIT) : 8'hFF;

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(wr_stb) |-> ((dout & KEEP) == ($past(dout) & KEEP)));

  assert_pulse_source_R6: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(dout[PULSE_BIT]) |-> $past(wr_stb));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_s)
    $past(dis) |-> flag);

  assert_pull_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(pull) |-> $past(scl_fall));

endmodule

bind tmr_bus_slave tmr_bus_slave_chk #(.PULSE_EN(PULSE_EN), .PULSE_BIT(PULSE_BIT)) u_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .dout     (dout),
  .wr_stb   (wr_stb),
  .pull     (bus_sda_pull),
  .scl_fall (scl_fall),
  .dis      (any_dis),
  .flag     (flag_q)
);

// File: tb/tmr_bus_slave_bench.sv
`timescale 1ns/1ps
module tmr_bus_slave_bench;

  localparam int HP = 8;
  localparam int NV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] chip_id = 2'b10;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       pull;
  logic [7:0] dout;
  logic       sda_bus;

  assign sda_bus = sda_m & ~pull;

  always #4 clk = ~clk;

  tmr_bus_slave u_tmr_bus_slave (
    .clk          (clk),
    .rst_n        (rst_n),
    .chip_id      (chip_id),
    .bus_scl      (scl_m),
    .bus_sda      (sda_bus),
    .bus_sda_pull (pull),
    .dout         (dout)
  );

  int checks = 0;
  int failures = 0;
  int hi_cnt = 0;

  always @(posedge clk) if (dout[7]) hi_cnt <= hi_cnt + 1;

  // {addr, data, addr_mask, data_mask, exp_addr_ack, exp_data_ack, exp_dout}
  localparam logic [49:0] VEC [NV] = '{
    {8'hA4, 8'h5A, 12'h000, 12'h000, 1'b1, 1'b1, 8'h5A},
    {8'hA4, 8'h3C, 12'h040, 12'h000, 1'b1, 1'b1, 8'h3C},
    {8'hA4, 8'h81, 12'h000, 12'h001, 1'b1, 1'b1, 8'h01},
    {8'hA4, 8'hF0, 12'h000, 12'h090, 1'b1, 1'b0, 8'h01},
    {8'hA6, 8'h77, 12'h000, 12'h000, 1'b0, 1'b0, 8'h01},
    {8'hA4, 8'h00, 12'h0A0, 12'h000, 1'b0, 1'b0, 8'h01},
    {8'hA4, 8'h99, 12'h000, 12'h800, 1'b1, 1'b1, 8'h19},
    {8'hA4, 8'h66, 12'h000, 12'h000, 1'b1, 1'b1, 8'h66}
  };

  function automatic logic [11:0] enc(input logic [7:0] d);
    logic [11:0] c;
    c[0]  = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    c[1]  = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c[2]  = d[0];
    c[3]  = d[1] ^ d[2] ^ d[3] ^ d[7];
    c[4]  = d[1]; c[5] = d[2]; c[6] = d[3];
    c[7]  = d[4] ^ d[5] ^ d[6] ^ d[7];
    c[8]  = d[4]; c[9] = d[5]; c[10] = d[6]; c[11] = d[7];
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(HP);
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b0; tick(HP/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HP/2);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b1; tick(HP);
  endtask

  task automatic send_word(input logic [11:0] w, output logic ack);
    for (int i = 11; i >= 0; i--) begin
      sda_m = w[i]; tick(HP/2);
      scl_m = 1'b1; tick(HP);
      scl_m = 1'b0; tick(HP/2);
    end
    sda_m = 1'b1; tick(HP/2);
    scl_m = 1'b1; tick(HP/2);
    ack = ~sda_bus;
    tick(HP/2);
    scl_m = 1'b0; tick(HP/2);
  endtask

  task automatic recv_word(input logic master_ack, output logic [11:0] w);
    sda_m = 1'b1;
    for (int i = 11; i >= 0; i--) begin
      tick(HP/2);
      scl_m = 1'b1; tick(HP/2);
      w[i] = sda_bus;
      tick(HP/2);
      scl_m = 1'b0; tick(HP/2);
    end
    sda_m = ~master_ack; tick(HP/2);
    scl_m = 1'b1; tick(HP);
    scl_m = 1'b0; tick(HP/2);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic [11:0] am,
                          input logic [11:0] dm, output logic aa, output logic da);
    bus_start();
    send_word(enc(a) ^ am, aa);
    send_word(enc(d) ^ dm, da);
    bus_stop();
    tick(40);
  endtask

  task automatic do_read(output logic aa, output logic [11:0] w0, output logic [11:0] w1);
    bus_start();
    send_word(enc(8'hA5), aa);
    recv_word(1'b1, w0);
    recv_word(1'b0, w1);
    bus_stop();
    tick(20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic aa, da;
    logic [11:0] w0, w1;
    tick(5);
    rst_n = 1'b1;
    tick(10);
    // R9 reset state
    check(dout == 8'h00, "R9 dout after reset", 32'(dout), 32'h0);
    check(pull == 1'b0, "R9 pull after reset", 32'(pull), 32'h0);

    // table walk: R1 R2 R3 R4 R6 R10
    for (int k = 0; k < NV; k++) begin
      do_write(VEC[k][49:42], VEC[k][41:34], VEC[k][33:22], VEC[k][21:10], aa, da);
      check(aa == VEC[k][9], "R1/R10 address ack", 32'(aa), 32'(VEC[k][9]));
      check(da == VEC[k][8], "R2/R3 data ack", 32'(da), 32'(VEC[k][8]));
      check(dout == VEC[k][7:0], "R4 dout after frame", 32'(dout), 32'(VEC[k][7:0]));
    end

    // R5 read back
    do_read(aa, w0, w1);
    check(aa == 1'b1, "R5 read address ack", 32'(aa), 32'h1);
    check(w0 == enc(8'h02), "R5 status byte", 32'(w0), 32'(enc(8'h02)));
    check(w1 == enc(8'h66), "R5 output byte", 32'(w1), 32'(enc(8'h66)));

    // R6 pulse length
    hi_cnt = 0;
    do_write(8'hA4, 8'h82, 12'h000, 12'h000, aa, da);
    check(hi_cnt == 16, "R6 pulse length", 32'(hi_cnt), 32'd16);
    check(dout == 8'h02, "R6 pulse cleared", 32'(dout), 32'h02);

    // R7 / R8 single-copy upset
    @(negedge clk);
    force u_tmr_bus_slave.u_state_tmr.copy_b = '1;
    @(posedge clk);
    #1 release u_tmr_bus_slave.u_state_tmr.copy_b;
    check(dout == 8'h02, "R7 dout during upset", 32'(dout), 32'h02);
    tick(5);
    check(dout == 8'h02, "R7 dout after scrub", 32'(dout), 32'h02);
    do_read(aa, w0, w1);
    check(w0 == enc(8'h82), "R8 upset flag set", 32'(w0), 32'(enc(8'h82)));
    check(w1 == enc(8'h02), "R7 output byte intact", 32'(w1), 32'(enc(8'h02)));
    do_write(8'hA4, 8'h11, 12'h000, 12'h000, aa, da);
    do_read(aa, w0, w1);
    check(w0 == enc(8'h02), "R8 flag cleared by write", 32'(w0), 32'(enc(8'h02)));
    check(w1 == enc(8'h11), "R4 output after write", 32'(w1), 32'(enc(8'h11)));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule